// File: doc/BRIEF.md
# Parameter Page Fetch Sequencer for Serial NAND

This controller runs the fixed command sequence that makes the identification (parameter) page of a serial NAND device readable and streams the chosen bytes of it to the caller. One start pulse latches a starting column and a byte count. The controller then switches the device into its one-time-programmable access mode and confirms the switch by reading the feature register back. It loads the parameter row into the device cache and polls the status register until the device is idle. Finally it reads the requested window out of the cache.

Whatever the outcome, the last frame always switches the access mode off again. The run ends with a single done pulse and a two-bit result code. Each failing phase has its own code. Entering the access mode and loading the page each have a bounded number of attempts. Each load also has a bounded number of status polls.

The controller does not drive the serial pins itself. It hands one byte at a time to a byte engine through a request/acknowledge pair. A flag marks the final byte of each frame, so the engine knows when to release chip select. The byte returned with each acknowledge is either checked by the sequencer or passed on to the output stream.

Top module: `pnf_param_fetch`

## Requirements
- R1: Every run opens with a three-byte frame 0x1F, 0xB0, 0x40, which writes feature register 0xB0 with only bit 6 (access enable) set. The frame-end flag is set on the third byte.
- R2: After each enable write, a frame 0x0F, 0xB0, 0x00 reads the register back, and the byte returned for the third slot is examined. If bit 6 of that byte is 1, the run goes on to the page load. If bit 6 is 0, the write and the read-back are repeated, up to REG_TRIES attempts in all. When every attempt fails, the result code is 1.
- R3: The page load is the four-byte frame 0x13, 0x00, 0x00, 0x04, which carries row address 0x000004 with the most significant byte first.
- R4: After each load, the frame 0x0F, 0xC0, 0x00 is repeated while bit 0 of the returned byte is 1, and other bits are ignored. Each load allows at most POLL_LIMIT such polls. When they run out, the page is loaded again, up to LOAD_TRIES loads in all. When every load fails, the result code is 2.
- R5: The cache read frame sends the opcode (0x03, or 0x0B when FAST_READ=1), then the column high byte, then the column low byte. A dummy byte 0x00 follows when FAST_READ=1 or SLOW_DUMMY=1. Then come length data slots transmitting 0x00, with the frame-end flag on the last one. Each byte returned in a data slot appears on out_data_o with out_valid_o high for one cycle, in the cycle after its acknowledge.
- R6: If the length is 0, or column plus length exceeds PAGE_SPAN, no cache read frame is sent and the result code is 3. A window that ends exactly at PAGE_SPAN is read normally.
- R7: Every run, successful or not, ends with the frame 0x1F, 0xB0, 0x00, which clears the access enable.
- R8: done_o is high for exactly one cycle, in the cycle after the acknowledge of the last byte of the closing frame. busy_o falls in that same cycle. err_o then holds the result code (0 on success) until the next start.
- R9: spi_req_o stays high, with spi_tx_o and spi_last_o unchanged, until spi_ack_i is seen. It is low for at least one cycle after each acknowledge, and it is never high while busy_o is low.
- R10: start_i has no effect while busy_o is high: the running sequence, its latched column and length, and its single done pulse are unchanged.
- R11: After reset, busy_o, done_o, err_o, out_valid_o and spi_req_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a run (accepted only when idle) |
| col_i | input | 16 | First cache column to read |
| len_i | input | LEN_W | Number of bytes to read |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 2 | Result: 0 ok, 1 enable failed, 2 load failed, 3 read rejected |
| out_valid_o | output | 1 | out_data_o carries a page byte |
| out_data_o | output | 8 | Page byte from the cache read |
| spi_req_o | output | 1 | Byte request to the byte engine |
| spi_tx_o | output | 8 | Byte to transmit |
| spi_last_o | output | 1 | Byte ends the current frame |
| spi_ack_i | input | 1 | Byte engine finished the byte |
| spi_rx_i | input | 8 | Byte received during that transfer |

## Verification
The sharpest coincidence is a budget running out on the same response that reports success. The final permitted status poll can return idle just as the poll counter reaches its limit. Likewise, the final permitted read-back can show the enable bit just as the attempt counter is exhausted. The bench's device model is set to stay busy for exactly POLL_LIMIT-1 polls, or to refuse exactly REG_TRIES-1 read-backs. The outcome is judged from the captured frame list and the result code: a correct design proceeds to the read with code 0, not to a reload or an error exit.

// File: rtl/pnf_pkg.sv
package pnf_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_EN_SET,
    PH_EN_GET,
    PH_LOAD,
    PH_POLL,
    PH_READ,
    PH_EXIT
  } phase_t;

  localparam logic [1:0] RES_OK     = 2'd0;
  localparam logic [1:0] RES_ENABLE = 2'd1;
  localparam logic [1:0] RES_LOAD   = 2'd2;
  localparam logic [1:0] RES_READ   = 2'd3;

  localparam logic [7:0] OP_FEAT_WR  = 8'h1F;
  localparam logic [7:0] OP_FEAT_RD  = 8'h0F;
  localparam logic [7:0] OP_LOAD     = 8'h13;
  localparam logic [7:0] OP_RD_SLOW  = 8'h03;
  localparam logic [7:0] OP_RD_FAST  = 8'h0B;
  localparam logic [7:0] ADDR_CFG    = 8'hB0;
  localparam logic [7:0] ADDR_STAT   = 8'hC0;
  localparam logic [7:0] CFG_ENTER   = 8'h40;
  localparam logic [7:0] CFG_LEAVE   = 8'h00;
  localparam logic [23:0] PAGE_ROW   = 24'h000004;
  localparam int ENABLE_BIT = 6;
  localparam int BUSY_BIT   = 0;

endpackage

// File: rtl/pnf_step_counter.sv
module pnf_step_counter #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic at_last
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (inc && !at_last) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign at_last = (int'(cnt_q) == LIMIT - 1);
endmodule

// File: rtl/pnf_frame_gen.sv
module pnf_frame_gen
  import pnf_pkg::*;
#(
  parameter int LEN_W      = 12,
  parameter bit FAST_READ  = 1'b0,
  parameter bit SLOW_DUMMY = 1'b1
) (
  input  phase_t           phase,
  input  logic [LEN_W:0]   idx,
  input  logic [15:0]      col,
  input  logic [LEN_W-1:0] len,
  output logic [7:0]       tx_byte,
  output logic             last,
  output logic             data_slot
);
  localparam int HDR = (FAST_READ || SLOW_DUMMY) ? 4 : 3;

  logic [7:0]     rd_op;
  logic [LEN_W:0] rd_end;

  generate
    if (FAST_READ) begin : g_fast
      assign rd_op = OP_RD_FAST;
    end else begin : g_slow
      assign rd_op = OP_RD_SLOW;
    end
  endgenerate

  assign rd_end = {1'b0, len} + (LEN_W+1)'(HDR - 1);

  always_comb begin
    tx_byte   = 8'h00;
    last      = 1'b0;
    data_slot = 1'b0;
    unique case (phase)
      PH_EN_SET, PH_EXIT: begin
        case (idx)
          0:       tx_byte = OP_FEAT_WR;
          1:       tx_byte = ADDR_CFG;
          default: tx_byte = (phase == PH_EN_SET) ? CFG_ENTER : CFG_LEAVE;
        endcase
        last = (idx == 2);
      end
      PH_EN_GET, PH_POLL: begin
        case (idx)
          0:       tx_byte = OP_FEAT_RD;
          1:       tx_byte = (phase == PH_EN_GET) ? ADDR_CFG : ADDR_STAT;
          default: tx_byte = 8'h00;
        endcase
        last = (idx == 2);
      end
      PH_LOAD: begin
        case (idx)
          0:       tx_byte = OP_LOAD;
          1:       tx_byte = PAGE_ROW[23:16];
          2:       tx_byte = PAGE_ROW[15:8];
          default: tx_byte = PAGE_ROW[7:0];
        endcase
        last = (idx == 3);
      end
      PH_READ: begin
        case (idx)
          0:       tx_byte = rd_op;
          1:       tx_byte = col[15:8];
          2:       tx_byte = col[7:0];
          default: tx_byte = 8'h00;
        endcase
        last      = (idx == rd_end);
        data_slot = (idx >= (LEN_W+1)'(HDR));
      end
      default: begin
        tx_byte = 8'h00;
      end
    endcase
  end
endmodule

// File: rtl/pnf_param_fetch.sv
module pnf_param_fetch
  import pnf_pkg::*;
#(
  parameter int LEN_W      = 12,
  parameter int PAGE_SPAN  = 2176,
  parameter int REG_TRIES  = 3,
  parameter int LOAD_TRIES = 3,
  parameter int POLL_LIMIT = 1000,
  parameter bit FAST_READ  = 1'b0,
  parameter bit SLOW_DUMMY = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [15:0]      col_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       err_o,
  output logic             out_valid_o,
  output logic [7:0]       out_data_o,
  output logic             spi_req_o,
  output logic [7:0]       spi_tx_o,
  output logic             spi_last_o,
  input  logic             spi_ack_i,
  input  logic [7:0]       spi_rx_i
);
  phase_t           phase_q;
  logic [LEN_W:0]   idx_q;
  logic [15:0]      col_q;
  logic [LEN_W-1:0] len_q;
  logic             req_q, last_q, busy_q, done_q, ov_q;
  logic [7:0]       tx_q, od_q;
  logic [1:0]       err_q;

  logic [7:0] fg_tx;
  logic       fg_last, fg_data;
  logic       frame_end, accept, rd_bad;
  logic       en_ok, stat_busy;
  logic       reg_clr, reg_inc, reg_last;
  logic       load_inc, load_last;
  logic       poll_clr, poll_inc, poll_last;
  logic [31:0] win_end;

  pnf_frame_gen #(
    .LEN_W(LEN_W), .FAST_READ(FAST_READ), .SLOW_DUMMY(SLOW_DUMMY)
  ) u_frame (
    .phase(phase_q), .idx(idx_q), .col(col_q), .len(len_q),
    .tx_byte(fg_tx), .last(fg_last), .data_slot(fg_data)
  );

  assign accept    = (phase_q == PH_IDLE) && start_i;
  assign frame_end = req_q && spi_ack_i && fg_last;
  assign en_ok     = spi_rx_i[ENABLE_BIT];
  assign stat_busy = spi_rx_i[BUSY_BIT];
  assign win_end   = 32'(col_q) + 32'(len_q);
  assign rd_bad    = (len_q == '0) || (win_end > 32'(PAGE_SPAN));

  always_comb begin
    reg_clr  = accept;
    reg_inc  = frame_end && (phase_q == PH_EN_GET) && !en_ok;
    poll_clr = frame_end && (phase_q == PH_LOAD);
    poll_inc = frame_end && (phase_q == PH_POLL) && stat_busy;
    load_inc = poll_inc && poll_last;
  end

  pnf_step_counter #(.LIMIT(REG_TRIES)) u_reg_cnt (
    .clk(clk), .rst(rst), .clr(reg_clr), .inc(reg_inc), .at_last(reg_last)
  );

  pnf_step_counter #(.LIMIT(LOAD_TRIES)) u_load_cnt (
    .clk(clk), .rst(rst), .clr(reg_clr), .inc(load_inc), .at_last(load_last)
  );

  pnf_step_counter #(.LIMIT(POLL_LIMIT)) u_poll_cnt (
    .clk(clk), .rst(rst), .clr(poll_clr), .inc(poll_inc), .at_last(poll_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      col_q   <= '0;
      len_q   <= '0;
      req_q   <= 1'b0;
      tx_q    <= 8'h00;
      last_q  <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= RES_OK;
      ov_q    <= 1'b0;
      od_q    <= 8'h00;
    end else begin
      done_q <= 1'b0;
      ov_q   <= 1'b0;
      if (phase_q == PH_IDLE) begin
        if (start_i) begin
          col_q   <= col_i;
          len_q   <= len_i;
          busy_q  <= 1'b1;
          err_q   <= RES_OK;
          idx_q   <= '0;
          phase_q <= PH_EN_SET;
        end
      end else if (!req_q) begin
        req_q  <= 1'b1;
        tx_q   <= fg_tx;
        last_q <= fg_last;
      end else if (spi_ack_i) begin
        req_q <= 1'b0;
        if ((phase_q == PH_READ) && fg_data) begin
          ov_q <= 1'b1;
          od_q <= spi_rx_i;
        end
        if (!fg_last) begin
          idx_q <= idx_q + 1'b1;
        end else begin
          idx_q <= '0;
          unique case (phase_q)
            PH_EN_SET: phase_q <= PH_EN_GET;
            PH_EN_GET: begin
              if (en_ok) begin
                phase_q <= PH_LOAD;
              end else if (reg_last) begin
                err_q   <= RES_ENABLE;
                phase_q <= PH_EXIT;
              end else begin
                phase_q <= PH_EN_SET;
              end
            end
            PH_LOAD: phase_q <= PH_POLL;
            PH_POLL: begin
              if (!stat_busy) begin
                if (rd_bad) begin
                  err_q   <= RES_READ;
                  phase_q <= PH_EXIT;
                end else begin
                  phase_q <= PH_READ;
                end
              end else if (poll_last) begin
                if (load_last) begin
                  err_q   <= RES_LOAD;
                  phase_q <= PH_EXIT;
                end else begin
                  phase_q <= PH_LOAD;
                end
              end
            end
            PH_READ: phase_q <= PH_EXIT;
            PH_EXIT: begin
              phase_q <= PH_IDLE;
              busy_q  <= 1'b0;
              done_q  <= 1'b1;
            end
            default: phase_q <= PH_IDLE;
          endcase
        end
      end
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign out_valid_o = ov_q;
  assign out_data_o  = od_q;
  assign spi_req_o   = req_q;
  assign spi_tx_o    = tx_q;
  assign spi_last_o  = last_q;
endmodule

// File: rtl/pnf_param_fetch_chk.sv
module pnf_param_fetch_chk (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic [1:0] err_o,
  input logic       out_valid_o,
  input logic       spi_req_o,
  input logic [7:0] spi_tx_o,
  input logic       spi_last_o,
  input logic       spi_ack_i
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (spi_req_o && !spi_ack_i) |=> (spi_req_o && $stable(spi_tx_o) && $stable(spi_last_o))); // R9

  AST_REQ_GAP: assert property (@(posedge clk) disable iff (rst)
    (spi_req_o && spi_ack_i) |=> !spi_req_o); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !spi_req_o); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o); // R8

  AST_ERR_HELD: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> $stable(err_o)); // R8

  AST_STREAM_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> busy_o); // R5
endmodule

bind pnf_param_fetch pnf_param_fetch_chk u_chk (.*);

// File: tb/pnf_param_fetch_bench.sv
module pnf_param_fetch_bench;
  localparam int LEN_W = 12;
  localparam int SPAN  = 2176;
  localparam int REG_T = 3;
  localparam int LOAD_T = 2;
  localparam int POLL_L = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [15:0]      col_i = '0;
  logic [LEN_W-1:0] len_i = '0;
  logic             busy_o, done_o, out_valid_o, spi_req_o, spi_last_o;
  logic [1:0]       err_o;
  logic [7:0]       out_data_o, spi_tx_o;
  logic             spi_ack_i = 1'b0;
  logic [7:0]       spi_rx_i = 8'h00;

  always #10 clk = ~clk;

  pnf_param_fetch #(
    .LEN_W(LEN_W), .PAGE_SPAN(SPAN), .REG_TRIES(REG_T), .LOAD_TRIES(LOAD_T),
    .POLL_LIMIT(POLL_L), .FAST_READ(1'b0), .SLOW_DUMMY(1'b1)
  ) u_pnf_param_fetch (
    .clk(clk), .rst(rst), .start_i(start_i), .col_i(col_i), .len_i(len_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .out_valid_o(out_valid_o),
    .out_data_o(out_data_o), .spi_req_o(spi_req_o), .spi_tx_o(spi_tx_o),
    .spi_last_o(spi_last_o), .spi_ack_i(spi_ack_i), .spi_rx_i(spi_rx_i)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  logic [7:0] log_tx [0:511];
  logic       log_last [0:511];
  int         log_n = 0;
  logic [7:0] exp_tx [0:511];
  logic       exp_last [0:511];
  string      exp_tag [0:511];
  int         exp_n = 0;
  logic [7:0] str_d [0:511];
  int         str_n = 0;
  int         done_cnt = 0;
  logic [1:0] err_at_done = 2'd0;

  int m_fails = 0;
  int m_busy = 0;
  int m_rb = 0;
  int m_poll = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] page_byte(input int pos);
    return 8'(pos) ^ 8'hA5;
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid_o && str_n < 512) begin
        str_d[str_n] = out_data_o;
        str_n++;
      end
      if (!rst && done_o) begin
        done_cnt++;
        err_at_done = err_o;
      end
    end
  end

  initial begin
    logic [7:0] fb [0:3];
    int fidx;
    logic [7:0] rx;
    fidx = 0;
    forever begin
      @(negedge clk);
      if (spi_req_o) begin
        repeat (2) @(negedge clk);
        if (fidx < 4) fb[fidx] = spi_tx_o;
        rx = 8'h00;
        if (fidx == 0 && spi_tx_o == 8'h13) m_poll = 0;
        if (fidx == 2 && fb[0] == 8'h0F && fb[1] == 8'hB0) begin
          rx = (m_rb < m_fails) ? 8'hBF : 8'h40;
          m_rb++;
        end
        if (fidx == 2 && fb[0] == 8'h0F && fb[1] == 8'hC0) begin
          rx = (m_poll < m_busy) ? 8'h01 : 8'h3C;
          m_poll++;
        end
        if (fidx >= 4 && (fb[0] == 8'h03 || fb[0] == 8'h0B))
          rx = page_byte(int'({fb[1], fb[2]}) + fidx - 4);
        if (log_n < 512) begin
          log_tx[log_n] = spi_tx_o;
          log_last[log_n] = spi_last_o;
          log_n++;
        end
        fidx = spi_last_o ? 0 : fidx + 1;
        spi_rx_i = rx;
        spi_ack_i = 1'b1;
        @(negedge clk);
        spi_ack_i = 1'b0;
      end
    end
  end

  task automatic push(input logic [7:0] b, input logic l, input string tag);
    exp_tx[exp_n] = b;
    exp_last[exp_n] = l;
    exp_tag[exp_n] = tag;
    exp_n++;
  endtask

  task automatic build(input int col, input int len, input int fails, input int busyn,
                       output int experr);
    bit ok, ready;
    int np;
    exp_n = 0;
    experr = 0;
    ok = 0;
    for (int a = 0; a < REG_T && !ok; a++) begin
      push(8'h1F, 0, "R1"); push(8'hB0, 0, "R1"); push(8'h40, 1, "R1");
      push(8'h0F, 0, "R2"); push(8'hB0, 0, "R2"); push(8'h00, 1, "R2");
      if (a >= fails) ok = 1;
    end
    if (!ok) begin
      experr = 1;
    end else begin
      ready = 0;
      for (int l = 0; l < LOAD_T && !ready; l++) begin
        push(8'h13, 0, "R3"); push(8'h00, 0, "R3"); push(8'h00, 0, "R3"); push(8'h04, 1, "R3");
        np = (busyn < POLL_L) ? busyn + 1 : POLL_L;
        for (int p = 0; p < np; p++) begin
          push(8'h0F, 0, "R4"); push(8'hC0, 0, "R4"); push(8'h00, 1, "R4");
        end
        if (busyn < POLL_L) ready = 1;
      end
      if (!ready) begin
        experr = 2;
      end else if (len == 0 || col + len > SPAN) begin
        experr = 3;
      end else begin
        push(8'h03, 0, "R5"); push(8'(col >> 8), 0, "R5"); push(8'(col), 0, "R5");
        push(8'h00, 0, "R5");
        for (int k = 0; k < len; k++) push(8'h00, (k == len - 1), "R5");
      end
    end
    push(8'h1F, 0, "R7"); push(8'hB0, 0, "R7"); push(8'h00, 1, "R7");
  endtask

  task automatic run(input int col, input int len, input int fails, input int busyn,
                     input bit poke, input string tag);
    int experr, d0, ne;
    m_fails = fails;
    m_busy = busyn;
    m_rb = 0;
    m_poll = 0;
    log_n = 0;
    str_n = 0;
    d0 = done_cnt;
    build(col, len, fails, busyn, experr);
    @(negedge clk);
    col_i = 16'(col);
    len_i = LEN_W'(len);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check({tag, " busy after start"}, busy_o, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      col_i = 16'h0123;
      len_i = LEN_W'(9);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (done_cnt == d0) @(negedge clk);
    repeat (40) @(negedge clk);
    check({tag, " R8 single done"}, done_cnt - d0, 1);
    check({tag, " R8 result code"}, err_at_done, experr);
    check({tag, " R8 code held"}, err_o, experr);
    check({tag, " R8 idle after"}, busy_o, 0);
    check({tag, " R7 frame byte count"}, log_n, exp_n);
    ne = (log_n < exp_n) ? log_n : exp_n;
    for (int i = 0; i < ne; i++) begin
      check({tag, " ", exp_tag[i], " tx"}, log_tx[i], exp_tx[i]);
      check({tag, " ", exp_tag[i], " last"}, log_last[i], exp_last[i]);
    end
    check({tag, " R5 stream count"}, str_n, (experr == 0) ? len : 0);
    for (int k = 0; k < str_n && k < len; k++)
      check({tag, " R5 stream byte"}, str_d[k], page_byte(col + k));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 busy", busy_o, 0);
    check("R11 done", done_o, 0);
    check("R11 err", err_o, 0);
    check("R11 out_valid", out_valid_o, 0);
    check("R11 req", spi_req_o, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 no request when idle", spi_req_o, 0);

    run(16'h0010, 5, 0, 2, 0, "basic");
    run(16'h0000, 3, 1, 0, 0, "R2 one refused readback");
    run(16'h0000, 3, REG_T - 1, 0, 0, "R2 last readback accepted");
    run(16'h0000, 3, 99, 0, 0, "R2 enable never set");
    run(16'h0004, 2, 0, POLL_L - 1, 0, "R4 ready on last poll");
    run(16'h0004, 2, 0, 99, 0, "R4 never ready");
    run(16'h0000, 0, 0, 0, 0, "R6 zero length");
    run(SPAN - 2, 3, 0, 0, 0, "R6 past end");
    run(SPAN - 2, 2, 0, 1, 0, "R6 exact end");
    run(16'h0100, 6, 0, 1, 1, "R10 start while busy");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule